// File: doc/BRIEF.md
# Sequential Dial Combination Lock

This block is a clocked state machine modelling a rotary combination lock. Each dial operation arrives as one transfer on a valid/ready input. A transfer carries a turn direction and the dial number where the turn stopped. The lock opens only when three operations arrive in the right order: right to 13, then left to 22, then right to 3. Entering the same numbers in another order does not open it. Progress is held in four states: idle, one step done, two steps done, and open. The open output is a pure function of the state.

A transfer takes place on a rising clock edge where `op_valid` and `op_ready` are both high. `op_ready` is high in every state except open. While the lock is open it applies back-pressure, so any operation offered then is not consumed and has no effect. A source may hold `op_valid` high with stable data for as long as it likes. The relock input, or the synchronous reset, sends the machine back to idle. The combination is fixed by parameters and cannot change at run time.

Top module: `dial_combo_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `lock_open` = 0 and `op_ready` = 1 (idle).
- R2: Three accepted operations in the order right-13, left-22, right-3 (`op_right` = 1 means right) set `lock_open` to 1 in the cycle after the third accepted operation.
- R3: `lock_open` is 0 in idle and after only one or two correct steps. It is high only in the fourth state.
- R4: An edge with no accepted operation leaves the state unchanged, so idle cycles between correct steps still lead to opening.
- R5: An accepted operation whose direction or number differs from the expected next step returns the machine to idle, and the whole sequence must then be entered again.
- R6: The correct values in a wrong order, for example left-22, right-13, right-3, do not open the lock.
- R7: A dial value above 39 never matches a step and returns the machine to idle.
- R8: While open, `op_ready` is 0, offered operations are ignored, and `lock_open` stays 1 until relock or reset.
- R9: `relock` high at an edge gives idle in the next cycle (`lock_open` = 0, `op_ready` = 1). It takes priority over an operation offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| relock | input | 1 | Synchronous return to idle |
| op_valid | input | 1 | A completed dial operation is offered |
| op_ready | output | 1 | Lock can take an operation (low while open) |
| op_right | input | 1 | Turn direction, 1 = right, 0 = left |
| op_dial | input | 6 | Dial number where the turn stopped, 0 to 39 |
| lock_open | output | 1 | High only in the open state |

## Verification
The hardest cases to reach are those where a correct-looking operation arrives in the wrong context. Examples are a right-13 that lands in the middle of a sequence, a relock in the same cycle as an operation, and an operation offered while ready is low. The stimulus builds partial progress first and then injects the offending operation. Every case ends with a follow-up operation whose outcome differs between idle and the other states, so the hidden progress becomes visible on `lock_open` and `op_ready`.

// File: rtl/dlock_pkg.sv
package dlock_pkg;
  localparam int DIAL_W = 6;
  localparam int STEPS  = 3;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_ONE  = 2'd1,
    LK_TWO  = 2'd2,
    LK_OPEN = 2'd3
  } lk_state_e;

  typedef struct packed {
    logic              turn_right;
    logic [DIAL_W-1:0] pos;
  } step_t;
endpackage

// File: rtl/dlock_step_table.sv
module dlock_step_table
  import dlock_pkg::*;
#(
  parameter logic [STEPS-1:0]        COMBO_RIGHT = 3'b101,
  parameter logic [STEPS*DIAL_W-1:0] COMBO_POS   = {6'd3, 6'd22, 6'd13}
) (
  input  lk_state_e state,
  output step_t     expect_step,
  output logic      expect_valid
);
  step_t tbl [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_tbl
    assign tbl[g].turn_right = COMBO_RIGHT[g];
    assign tbl[g].pos        = COMBO_POS[g*DIAL_W +: DIAL_W];
  end

  always_comb begin
    expect_valid = 1'b1;
    expect_step  = tbl[0];
    case (state)
      LK_IDLE: expect_step = tbl[0];
      LK_ONE:  expect_step = tbl[1];
      LK_TWO:  expect_step = tbl[2];
      default: begin
        expect_valid = 1'b0;
        expect_step  = '0;
      end
    endcase
  end
endmodule

// File: rtl/dlock_step_match.sv
module dlock_step_match
  import dlock_pkg::*;
#(
  parameter int DIAL_MAX = 39
) (
  input  step_t             expect_step,
  input  logic              expect_valid,
  input  logic              op_right,
  input  logic [DIAL_W-1:0] op_dial,
  output logic              hit
);
  localparam logic [DIAL_W-1:0] MAX_V = DIAL_W'(DIAL_MAX);

  logic in_range;
  assign in_range = (op_dial <= MAX_V);
  assign hit = expect_valid && in_range &&
               (op_right == expect_step.turn_right) &&
               (op_dial == expect_step.pos);
endmodule

// File: rtl/dlock_seq_fsm.sv
module dlock_seq_fsm
  import dlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      relock,
  input  logic      accept,
  input  logic      hit,
  output lk_state_e state,
  output logic      lock_open
);
  lk_state_e nxt;

  always_comb begin
    nxt = state;
    if (relock) begin
      nxt = LK_IDLE;
    end else if (accept) begin
      if (!hit) begin
        nxt = LK_IDLE;
      end else begin
        case (state)
          LK_IDLE: nxt = LK_ONE;
          LK_ONE:  nxt = LK_TWO;
          LK_TWO:  nxt = LK_OPEN;
          default: nxt = state;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LK_IDLE;
      lock_open <= 1'b0;
    end else begin
      state     <= nxt;
      lock_open <= (nxt == LK_OPEN);
    end
  end

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!accept && !relock) |=> $stable(state)); // R4
  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit && !relock) |=> (state == LK_IDLE)); // R5
  AST_RELOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    relock |=> (state == LK_IDLE && !lock_open)); // R9
  AST_OPEN_FROM_TWO: assert property (@(posedge clk) disable iff (rst)
    (accept && hit && !relock && state == LK_TWO) |=> lock_open); // R2
endmodule

// File: rtl/dial_combo_lock.sv
module dial_combo_lock
  import dlock_pkg::*;
#(
  parameter int                      DIAL_MAX    = 39,
  parameter logic [STEPS-1:0]        COMBO_RIGHT = 3'b101,
  parameter logic [STEPS*DIAL_W-1:0] COMBO_POS   = {6'd3, 6'd22, 6'd13}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              relock,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_right,
  input  logic [DIAL_W-1:0] op_dial,
  output logic              lock_open
);
  localparam logic [DIAL_W-1:0] MAX_V = DIAL_W'(DIAL_MAX);

  lk_state_e state;
  step_t     expect_step;
  logic      expect_valid;
  logic      hit;
  logic      accept;

  assign op_ready = !lock_open;
  assign accept   = op_valid && op_ready;

  dlock_step_table #(
    .COMBO_RIGHT(COMBO_RIGHT),
    .COMBO_POS  (COMBO_POS)
  ) u_table (
    .state       (state),
    .expect_step (expect_step),
    .expect_valid(expect_valid)
  );

  dlock_step_match #(.DIAL_MAX(DIAL_MAX)) u_match (
    .expect_step (expect_step),
    .expect_valid(expect_valid),
    .op_right    (op_right),
    .op_dial     (op_dial),
    .hit         (hit)
  );

  dlock_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .relock   (relock),
    .accept   (accept),
    .hit      (hit),
    .state    (state),
    .lock_open(lock_open)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!lock_open && op_ready)); // R1
  AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (lock_open && !relock) |=> lock_open); // R8
  AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (accept && op_dial > MAX_V && !relock) |=> (!lock_open && op_ready)); // R7
  AST_OPEN_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    (!lock_open && !(accept && state == LK_TWO)) |=> !lock_open); // R3
endmodule

// File: tb/tb_dial_combo_lock.sv
`timescale 1ns/1ps
module tb_dial_combo_lock;
  logic       clk = 1'b0;
  logic       rst, relock, op_valid, op_right;
  logic [5:0] op_dial;
  logic       op_ready, lock_open;

  always #2.5 clk = ~clk;

  dial_combo_lock dut (
    .clk(clk), .rst(rst), .relock(relock), .op_valid(op_valid),
    .op_ready(op_ready), .op_right(op_right), .op_dial(op_dial),
    .lock_open(lock_open)
  );

  typedef struct {
    logic  open_e;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // driver: one cycle of stimulus, expectation for the cycle after the edge
  task automatic cyc(input logic r, input logic rl, input logic v,
                     input logic dir, input logic [5:0] num,
                     input logic eo, input string req);
    exp_t e;
    @(negedge clk);
    rst = r; relock = rl; op_valid = v; op_right = dir; op_dial = num;
    e.open_e = eo; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic op(input logic dir, input logic [5:0] num, input logic eo, input string req);
    cyc(1'b0, 1'b0, 1'b1, dir, num, eo, req);
  endtask

  task automatic gap(input int n, input logic eo, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, eo, req);
  endtask

  task automatic do_relock(input string req);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, req);
  endtask

  // monitor: compares after each edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (lock_open !== e.open_e || op_ready !== !e.open_e) begin
          bad++;
          $display("FAIL %s: open=%b ready=%b expected open=%b ready=%b",
                   e.req, lock_open, op_ready, e.open_e, !e.open_e);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: open=%b ready=%b expected completion", lock_open, op_ready);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; relock = 1'b0; op_valid = 1'b0; op_right = 1'b0; op_dial = '0;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R1 reset");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 6'd13, 1'b0, "R1 reset holds idle");

    // R2 / R3 correct sequence
    op(1'b1, 6'd13, 1'b0, "R3 after one step");
    op(1'b0, 6'd22, 1'b0, "R3 after two steps");
    op(1'b1, 6'd3,  1'b1, "R2 opens");
    op(1'b1, 6'd13, 1'b1, "R8 op ignored while open");
    op(1'b0, 6'd40, 1'b1, "R8 bad op ignored while open");
    do_relock("R9 relock");

    // R4 gaps between steps
    op(1'b1, 6'd13, 1'b0, "R4 step1");
    gap(3, 1'b0, "R4 gap after step1");
    op(1'b0, 6'd22, 1'b0, "R4 step2");
    gap(2, 1'b0, "R4 gap after step2");
    op(1'b1, 6'd3,  1'b1, "R4 opens after gaps");
    gap(2, 1'b1, "R4 open holds over gaps");

    // R9 relock with concurrent op: op must not count
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 6'd13, 1'b0, "R9 relock beats op");
    op(1'b0, 6'd22, 1'b0, "R9 still idle");
    op(1'b1, 6'd3,  1'b0, "R9 no open from idle");

    // R5 wrong direction first step
    op(1'b0, 6'd13, 1'b0, "R5 wrong dir");
    op(1'b0, 6'd22, 1'b0, "R5 after wrong dir");
    op(1'b1, 6'd3,  1'b0, "R5 no open after wrong dir");
    // R5 wrong number on second step
    op(1'b1, 6'd13, 1'b0, "R5 s1");
    op(1'b0, 6'd21, 1'b0, "R5 wrong num");
    op(1'b1, 6'd3,  1'b0, "R5 no open after wrong num");
    // R5 wrong last step, then recovery
    op(1'b1, 6'd13, 1'b0, "R5 s1b");
    op(1'b0, 6'd22, 1'b0, "R5 s2b");
    op(1'b1, 6'd4,  1'b0, "R5 wrong last");
    op(1'b1, 6'd3,  1'b0, "R5 idle after wrong last");
    op(1'b1, 6'd13, 1'b0, "R5 retry s1");
    op(1'b0, 6'd22, 1'b0, "R5 retry s2");
    op(1'b1, 6'd3,  1'b1, "R5 retry opens");
    do_relock("R9 relock 2");

    // R6 wrong order of the right values
    op(1'b0, 6'd22, 1'b0, "R6 order a1");
    op(1'b1, 6'd13, 1'b0, "R6 order a2");
    op(1'b1, 6'd3,  1'b0, "R6 order a3");
    do_relock("R9 relock 3");
    op(1'b1, 6'd3,  1'b0, "R6 order b1");
    op(1'b1, 6'd13, 1'b0, "R6 order b2");
    op(1'b0, 6'd22, 1'b0, "R6 order b3");
    do_relock("R9 relock 4");

    // R7 out-of-range dial
    op(1'b1, 6'd13, 1'b0, "R7 s1");
    op(1'b0, 6'd22, 1'b0, "R7 s2");
    op(1'b1, 6'd63, 1'b0, "R7 dial 63 rejected");
    op(1'b1, 6'd3,  1'b0, "R7 idle after range miss");

    gap(2, 1'b0, "R4 final idle");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule